// File: doc/BRIEF.md
# MII Transmit Framer with Error-Marking Check Sequence

This block turns a byte stream from a transmit buffer into nibbles for the transmit side of a Media Independent Interface. It runs entirely on the transmit clock that the PHY supplies, 25 MHz at 100 Mb/s or 2.5 MHz at 10 Mb/s. For each frame it sends a preamble and a start-of-frame nibble, then the payload one nibble per clock, then a 32-bit CRC. It raises the transmit enable for exactly the length of that nibble sequence.

The upstream side offers bytes with a valid flag, a last-byte flag and an error flag. A ready output accepts one byte every two clocks. The block never uses the PHY's transmit-error pin, which it holds at zero. If any byte of a frame, the last one included, carries the error flag, the block completes the frame with the bitwise complement of the correct check sequence, so the receiver discards it. A buffer underrun gets the same treatment.

After each frame the block keeps the line quiet for an interframe gap before it starts the next one.

Top module: `mii_tx_framer`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, tx_en is 0, txd is 0 and in_ready is 0, whatever in_valid shows.
- R2: tx_er is 0 on every cycle.
- R3: When in_valid is 1 while the block is idle, tx_en rises on the next cycle. txd then carries 15 nibbles of 0x5 followed by one nibble of 0xD before any payload nibble.
- R4: Each accepted byte appears on txd over two consecutive cycles, bits [3:0] first and then bits [7:4]. A byte is accepted at a rising edge where in_ready and in_valid are both 1. in_ready is 1 on the 0xD cycle and on the high-nibble cycle of every byte that is not marked last.
- R5: Directly after the high nibble of the last byte, eight FCS nibbles follow. They are the IEEE 802.3 CRC-32 of the payload bytes (polynomial 0x04C11DB7, preset all ones, final complement), taken in the bit-reflected form, and nibble k carries reflected bits [4k+3:4k].
- R6: If in_err is 1 on any accepted byte of a frame, the last byte included, all eight FCS nibbles are the bitwise inverse of the R5 values.
- R7: If in_valid is 0 on a cycle where in_ready is 1, the payload ends there. The FCS over the bytes sent so far follows at once, inverted as in R6.
- R8: tx_en is 0 and txd is 0 on every cycle outside preamble, payload and FCS.
- R9: After the last FCS nibble, tx_en stays 0 for 24 cycles while in_valid is ignored. A new frame starts no earlier than the cycle after those 24, and its tx_en rises one cycle after the first idle cycle that sees in_valid.
- R10: in_ready is 0 on the high-nibble cycle of a byte accepted with in_last set, and it stays 0 until the next frame's 0xD cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock from the PHY; all state is clocked on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | 8 | Payload byte offered by the buffer |
| in_valid | input | 1 | in_data holds a byte; in idle it also requests a frame |
| in_last | input | 1 | The offered byte is the final payload byte |
| in_err | input | 1 | The offered byte belongs to a frame that must be rejected |
| in_ready | output | 1 | The block takes the offered byte at this clock edge |
| txd | output | 4 | Transmit nibble to the PHY |
| tx_en | output | 1 | txd carries frame nibbles |
| tx_er | output | 1 | Transmit error to the PHY, always 0 |

## Verification
The bench goes after the edges of the frame: the switch from 0xD to the first payload nibble, the handover from the last high nibble to the FCS, and the drop of tx_en after exactly eight FCS nibbles. If nibble order or CRC bit order is wrong, every FCS nibble differs from the bench's own check sequence, which it computes most-significant-first and then reverses.

For errors it flags only the middle byte in one frame and only the last byte in another. A design that samples the flag only once, or forgets it between bytes, sends a good FCS on one of them. An underrun frame checks that a missing byte ends the payload rather than stalling with tx_en high.

Frames are also requested during the gap and long after it. A design that counts the gap wrongly, or that honours in_valid during it, raises tx_en early.

// File: rtl/mii_tx_pkg.sv
package mii_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PRE  = 3'd1,
    ST_DATA = 3'd2,
    ST_FCS  = 3'd3,
    ST_GAP  = 3'd4
  } tx_state_e;

  localparam logic [31:0] CRC_PRESET = 32'hFFFF_FFFF;
  localparam logic [31:0] CRC_POLY_R = 32'hEDB8_8320;  // reflected 0x04C11DB7

  // One byte into the reflected CRC register, least significant bit first.
  function automatic logic [31:0] crc32_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int b = 0; b < 8; b++) begin
      if (r[0] ^ d[b]) r = (r >> 1) ^ CRC_POLY_R;
      else             r = r >> 1;
    end
    return r;
  endfunction

  // FCS nibble k of the running register; bad keeps the complement undone.
  function automatic logic [3:0] fcs_nibble(input logic [31:0] c, input logic [2:0] k,
                                            input logic bad);
    logic [31:0] f;
    f = bad ? c : ~c;
    return f[{k, 2'b00} +: 4];
  endfunction

endpackage

// File: rtl/mii_tx_seq.sv
module mii_tx_seq
  import mii_tx_pkg::*;
#(
  parameter int PRE_NIB = 15,
  parameter int GAP_CYC = 24,
  parameter int FCS_NIB = 8,
  localparam int CW     = $clog2(PRE_NIB + GAP_CYC + FCS_NIB) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_last,
  output tx_state_e     st,
  output logic [CW-1:0] cnt,
  output logic          phase,
  output logic          take,
  output logic          underrun,
  output logic          ready
);

  logic      last_q;
  tx_state_e st_n;
  logic [CW-1:0] cnt_n;
  logic      phase_n;

  assign ready    = (st == ST_PRE && cnt == CW'(PRE_NIB)) ||
                    (st == ST_DATA && phase && !last_q);
  assign take     = ready && in_valid;
  assign underrun = ready && !in_valid;

  always_comb begin
    st_n    = st;
    cnt_n   = cnt;
    phase_n = phase;
    unique case (st)
      ST_IDLE: if (in_valid) begin st_n = ST_PRE; cnt_n = '0; end
      ST_PRE: begin
        if (cnt == CW'(PRE_NIB)) begin
          cnt_n   = '0;
          phase_n = 1'b0;
          st_n    = take ? ST_DATA : ST_FCS;
        end else cnt_n = cnt + 1'b1;
      end
      ST_DATA: begin
        if (!phase) phase_n = 1'b1;
        else begin
          phase_n = 1'b0;
          if (last_q || !take) begin st_n = ST_FCS; cnt_n = '0; end
        end
      end
      ST_FCS: begin
        if (cnt == CW'(FCS_NIB - 1)) begin st_n = ST_GAP; cnt_n = '0; end
        else cnt_n = cnt + 1'b1;
      end
      ST_GAP: begin
        if (cnt == CW'(GAP_CYC - 1)) begin st_n = ST_IDLE; cnt_n = '0; end
        else cnt_n = cnt + 1'b1;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      phase  <= 1'b0;
      last_q <= 1'b0;
    end else begin
      st    <= st_n;
      cnt   <= cnt_n;
      phase <= phase_n;
      if (st == ST_IDLE) last_q <= 1'b0;
      else if (take)     last_q <= in_last;
    end
  end

  // R10: once the last byte is in, no further byte is asked for
  p_no_ready_after_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_last) |=> !ready);

endmodule

// File: rtl/mii_tx_crc.sv
module mii_tx_crc
  import mii_tx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          take,
  input  logic          underrun,
  input  logic [DW-1:0] in_data,
  input  logic          in_err,
  output logic [DW-1:0] byte_q,
  output logic [31:0]   crc_q,
  output logic          bad_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= '0;
      crc_q  <= CRC_PRESET;
      bad_q  <= 1'b0;
    end else if (clear) begin
      crc_q  <= CRC_PRESET;
      bad_q  <= 1'b0;
    end else begin
      if (take) begin
        byte_q <= in_data;
        crc_q  <= crc32_byte(crc_q, in_data);
      end
      if ((take && in_err) || underrun) bad_q <= 1'b1;
    end
  end

  // R7: an underrun marks the frame bad
  p_underrun_marks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !clear) |=> bad_q);

  // R6: an error mark is kept until the frame is over
  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_q && !clear) |=> bad_q);

endmodule

// File: rtl/mii_tx_framer.sv
module mii_tx_framer
  import mii_tx_pkg::*;
#(
  parameter int PRE_NIB = 15,
  parameter int GAP_CYC = 24
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  input  logic       in_last,
  input  logic       in_err,
  output logic       in_ready,
  output logic [3:0] txd,
  output logic       tx_en,
  output logic       tx_er
);

  localparam int FCS_NIB = 8;
  localparam int CW      = $clog2(PRE_NIB + GAP_CYC + FCS_NIB) + 1;
  localparam int GW      = $clog2(GAP_CYC + 1);

  tx_state_e     st;
  logic [CW-1:0] cnt;
  logic          phase, take, underrun;
  logic [7:0]    byte_q;
  logic [31:0]   crc_q;
  logic          bad_q;

  // named events for the checks
  logic in_pre, in_payload, in_fcs;
  assign in_pre     = (st == ST_PRE);
  assign in_payload = (st == ST_DATA);
  assign in_fcs     = (st == ST_FCS);

  mii_tx_seq #(.PRE_NIB(PRE_NIB), .GAP_CYC(GAP_CYC), .FCS_NIB(FCS_NIB)) u_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
    .st(st), .cnt(cnt), .phase(phase), .take(take), .underrun(underrun),
    .ready(in_ready)
  );

  mii_tx_crc #(.DW(8)) u_crc (
    .clk(clk), .rst_n(rst_n), .clear(st == ST_IDLE), .take(take),
    .underrun(underrun), .in_data(in_data), .in_err(in_err),
    .byte_q(byte_q), .crc_q(crc_q), .bad_q(bad_q)
  );

  always_comb begin
    unique case (st)
      ST_PRE:  txd = (cnt == CW'(PRE_NIB)) ? 4'hD : 4'h5;
      ST_DATA: txd = phase ? byte_q[7:4] : byte_q[3:0];
      ST_FCS:  txd = fcs_nibble(crc_q, cnt[2:0], bad_q);
      default: txd = 4'h0;
    endcase
  end

  assign tx_en = in_pre || in_payload || in_fcs;
  assign tx_er = 1'b0;

  // quiet-cycle counter for the gap check, saturating, preset full
  logic [GW-1:0] quiet_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         quiet_cnt <= GW'(GAP_CYC);
    else if (tx_en)                     quiet_cnt <= '0;
    else if (quiet_cnt != GW'(GAP_CYC)) quiet_cnt <= quiet_cnt + 1'b1;
  end

  // R9: a frame never starts inside the gap
  p_gap_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> quiet_cnt == GW'(GAP_CYC));

  // R4: bytes are only taken while a frame is on the line
  p_ready_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> tx_en);

  // R3: payload is always preceded by the delimiter nibble
  p_sfd_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_payload) |-> $past(txd) == 4'hD);

  // R5: the frame closes straight after the eighth FCS nibble
  p_fcs_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_en) |-> $past(in_fcs) && $past(cnt) == CW'(FCS_NIB - 1));

  // R8: the line is quiet outside a frame
  p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> txd == 4'h0 && !in_ready);

endmodule

// File: tb/mii_tx_framer_tb.sv
module mii_tx_framer_tb;

  localparam int CLK_PERIOD = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_valid = 1'b0, in_last = 1'b0, in_err = 1'b0;
  logic       in_ready, tx_en, tx_er;
  logic [3:0] txd;

  int checks = 0, errors = 0;
  int since = 1000;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mii_tx_framer u_dut (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_last(in_last), .in_err(in_err), .in_ready(in_ready),
    .txd(txd), .tx_en(tx_en), .tx_er(tx_er)
  );

  // reference CRC: MSB-first register, bits fed LSB first, result reversed
  function automatic logic [31:0] ref_fcs(input logic [7:0] b[$], input int n);
    logic [31:0] c = 32'hFFFF_FFFF;
    logic [31:0] f, r;
    for (int i = 0; i < n; i++)
      for (int j = 0; j < 8; j++) begin
        logic fb;
        fb = c[31] ^ b[i][j];
        c  = c << 1;
        if (fb) c = c ^ 32'h04C1_1DB7;
      end
    f = ~c;
    for (int j = 0; j < 32; j++) r[j] = f[31-j];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [3:0] et, input logic ee, input logic er);
    checks++;
    if (txd !== et || tx_en !== ee || in_ready !== er) begin
      errors++;
      $display("FAIL %s: txd/en/ready = %h/%b/%b expected %h/%b/%b",
               tag, txd, tx_en, in_ready, et, ee, er);
    end
    checks++;
    if (tx_er !== 1'b0) begin
      errors++;
      $display("FAIL R2: tx_er = %b expected 0", tx_er);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 0;
      since++;
      chk(since > 24 ? "R8" : "R9", 4'h0, 1'b0, 1'b0);
    end
  endtask

  // n bytes; errpos = byte carrying in_err (-1 none); under = byte never offered (-1 none)
  task automatic frame(input logic [7:0] b[$], input int errpos, input int under,
                       input bit hold_in_gap);
    logic [3:0] et[$];
    logic       ee[$], er[$];
    string      tg[$];
    int n = b.size();
    int sent = (under >= 1) ? under : n;
    bit bad = (under >= 1) || (errpos >= 0 && errpos < sent);
    logic [31:0] f;
    int z, idx;
    @(negedge clk);
    since++;
    in_valid = 1; in_data = b[0]; in_last = (n == 1); in_err = (errpos == 0);
    z = (since < 25 ? 25 - since : 0) + 1;
    for (int i = 0; i < z; i++) begin et.push_back(0); ee.push_back(0); er.push_back(0); tg.push_back("R9"); end
    for (int i = 0; i < 15; i++) begin et.push_back(5); ee.push_back(1); er.push_back(0); tg.push_back("R3"); end
    et.push_back(4'hD); ee.push_back(1); er.push_back(1); tg.push_back("R3");
    for (int i = 0; i < sent; i++) begin
      et.push_back(b[i][3:0]); ee.push_back(1); er.push_back(0); tg.push_back("R4");
      et.push_back(b[i][7:4]); ee.push_back(1); er.push_back(i != n-1);
      tg.push_back(i == n-1 ? "R10" : "R4");
    end
    f = ref_fcs(b, sent);
    if (bad) f = ~f;
    for (int k = 0; k < 8; k++) begin
      et.push_back(f[4*k +: 4]); ee.push_back(1); er.push_back(0);
      tg.push_back(under >= 1 ? "R7" : (bad ? "R6" : "R5"));
    end
    idx = 0;
    for (int c = 0; c < et.size(); c++) begin
      if (c > 0) begin
        @(negedge clk);
        if (er[c-1]) begin
          idx++;
          if (idx < n && idx != under) begin
            in_valid = 1; in_data = b[idx]; in_last = (idx == n-1); in_err = (idx == errpos);
          end else begin
            in_valid = 0; in_last = 0; in_err = 0;
          end
        end
      end
      chk(tg[c], et[c], ee[c], er[c]);
    end
    since = 0;
    in_valid = 0; in_last = 0; in_err = 0;
    if (hold_in_gap) begin
      // R9: requests during the gap must be ignored
      for (int i = 0; i < 24; i++) begin
        @(negedge clk);
        since++;
        in_valid = 1; in_data = 8'hA5;
        chk("R9", 4'h0, 1'b0, 1'b0);
      end
      in_valid = 0;
    end
  endtask

  initial begin
    logic [7:0] q[$];
    in_valid = 1;
    #(CLK_PERIOD*3 + CLK_PERIOD/2);
    chk("R1", 4'h0, 1'b0, 1'b0);
    @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    chk("R1", 4'h0, 1'b0, 1'b0);
    in_valid = 0;
    idle(2);
    q = '{8'h12, 8'h34, 8'h56, 8'h78};                    frame(q, -1, -1, 0);
    idle(3);
    q = '{8'hFF, 8'h00, 8'hC3, 8'h3C, 8'h81, 8'h7E};     frame(q, 2, -1, 0);
    idle(30);
    q = '{8'h31, 8'h32, 8'h33};                           frame(q, 2, -1, 1);
    q = '{8'h9A};                                         frame(q, -1, -1, 0);
    q = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05};             frame(q, -1, 2, 0);
    q = '{8'hDE, 8'hAD};                                  frame(q, -1, -1, 0);
    idle(40);
    q = '{8'h31,8'h32,8'h33,8'h34,8'h35,8'h36,8'h37,8'h38,8'h39}; frame(q, -1, -1, 0);
    idle(30);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule